// File: doc/BRIEF.md
# Receiver Acquisition Ramp Sequencer

This block sits behind the modem's 8-bit command register. Every byte written there updates three latched fields: the CRC start-state select, the transmit pulse-shape select and the 3-bit task code. Other logic reads these fields.

The same write can also launch two automatic acquisition ramps for the receiver, each under its own command bit. One ramp drives the bandwidth index of the symbol-timing loop. The other drives the response-speed index of the amplitude and DC-offset estimator. A launched ramp jumps to the fastest index. It then counts down one step at a time, paced by symbol ticks, until it reaches the normal index from the control register.

A launch happens only in receive mode, and only when the written task code is not RESET. A further launch write restarts a ramp from the top. A write with the bit clear leaves a running ramp alone. When no ramp is running, each index output follows its normal setting.

Top module: `acq_cmd_sequencer`

## Requirements
- R1: After a synchronous reset, `pll_busy` and `lev_busy` are low, `pll_idx` equals `pll_norm`, `lev_idx` equals `lev_norm`, and `crc_zero`, `tx_shape` and `task_code` are 0.
- R2: Every write (regardless of `rx_mode`) latches data bit 5 into `crc_zero` (1 = all-zeros CRC start, 0 = all-ones), bit 4 into `tx_shape` and bits 2..0 into `task_code`, visible the cycle after the write; bit 3 has no effect on any output.
- R3: A write with bit 7 = 1, `rx_mode` = 1 and bits 2..0 not equal to 3'b111 (RESET) sets `pll_idx` to its maximum (all ones) on the next cycle, with `pll_busy` high when `pll_norm` is below the maximum.
- R4: A write with bit 6 = 1 under the same conditions does the same for `lev_idx` and `lev_busy`; the two ramps are independent.
- R5: With `rx_mode` = 0, or with task code 3'b111 in the written byte, bits 7 and 6 launch no ramp.
- R6: While busy, an index falls by exactly one after every STEP_TICKS cycles with `sym_tick` high (default 4); busy drops in the same cycle the index reaches the normal value, and without ticks the index holds.
- R7: A launch write during a running ramp restarts it at the maximum index with the tick count cleared.
- R8: A write with the acquire bit at 0 leaves a running ramp's index and busy unchanged.
- R9: If the normal value rises to or above a running ramp's index, the ramp ends within one cycle at the normal value; when not busy, an index output equals its normal input.
- R10: If the normal value is already the maximum, a launch leaves busy low and the index at the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command byte |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| sym_tick | input | 1 | Symbol clock tick, one cycle wide |
| pll_norm | input | IDX_W | Normal timing-loop bandwidth index |
| lev_norm | input | IDX_W | Normal level-estimator response index |
| pll_idx | output | IDX_W | Current timing-loop bandwidth index |
| lev_idx | output | IDX_W | Current level-estimator response index |
| pll_busy | output | 1 | Timing-loop ramp in progress |
| lev_busy | output | 1 | Level ramp in progress |
| crc_zero | output | 1 | Latched CRC start-state select |
| tx_shape | output | 1 | Latched transmit shape select |
| task_code | output | 3 | Latched task code |

## Verification
The bench targets the gating cases. A byte carrying both acquire bits is written in transmit mode, and a launch byte is written with the RESET task code. A design that ignored either gate would raise busy and jump an index. A repeated launch mid-ramp must return the index to the top, and a design that ignored it would keep descending. A zero-bit write mid-ramp must change nothing, and a design that treated it as an abort would drop busy early. The bench also raises the normal value under a running ramp and launches with the normal value already at the maximum. A design that compared only for equality would either stall above the new normal value or hang busy forever.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam logic [2:0] TASK_RESET = 3'b111;

    typedef struct packed {
        logic       crc_zero;
        logic       tx_shape;
        logic [2:0] task_code;
    } cmd_fields_t;
endpackage

// File: rtl/acq_cmd_decode.sv
module acq_cmd_decode
    import acq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rx_mode,
    output cmd_fields_t fields,
    output logic        pll_start,
    output logic        lev_start
);
    cmd_fields_t fields_d, fields_q;
    logic        launch_ok;
    logic        unused_rsvd;

    assign unused_rsvd = wr_data[3];

    always_comb begin
        fields_d  = fields_q;
        launch_ok = wr_en && rx_mode && (wr_data[2:0] != TASK_RESET);
        if (wr_en) begin
            fields_d.crc_zero  = wr_data[5];
            fields_d.tx_shape  = wr_data[4];
            fields_d.task_code = wr_data[2:0];
        end
    end

    assign pll_start = launch_ok && wr_data[7];
    assign lev_start = launch_ok && wr_data[6];
    assign fields    = fields_q;

    always_ff @(posedge clk) begin
        if (rst) fields_q <= '0;
        else     fields_q <= fields_d;
    end

    a_r2_task_latch: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (fields_q.task_code == $past(wr_data[2:0])));
endmodule

// File: rtl/acq_ramp.sv
module acq_ramp #(
    parameter int IDX_W      = 3,
    parameter int STEP_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sym_tick,
    input  logic [IDX_W-1:0] norm,
    output logic [IDX_W-1:0] idx,
    output logic             busy
);
    localparam int               CNT_W   = $clog2(STEP_TICKS + 1);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEP_TICKS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } ramp_t;

    ramp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.idx  = IDX_MAX;
            st_d.cnt  = '0;
            st_d.busy = (IDX_MAX > norm);
        end else if (st_q.busy) begin
            if (st_q.idx <= norm) begin
                st_d.idx  = norm;
                st_d.cnt  = '0;
                st_d.busy = 1'b0;
            end else if (sym_tick) begin
                if (st_q.cnt == CNT_END) begin
                    st_d.cnt  = '0;
                    st_d.idx  = st_q.idx - IDX_ONE;
                    st_d.busy = ((st_q.idx - IDX_ONE) > norm);
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
        end else begin
            st_d.idx = norm;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.idx  <= norm;
            st_q.cnt  <= '0;
            st_q.busy <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy && (st_q.idx > norm);
    assign idx  = busy ? st_q.idx : norm;

    a_r3_start_at_max: assert property (@(posedge clk) disable iff (rst)
        start |=> (st_q.idx == IDX_MAX));

    a_r6_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && (st_q.idx > norm) && !start) |=>
            ((st_q.idx == $past(st_q.idx)) || (st_q.idx == $past(st_q.idx) - IDX_ONE)));

    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && (st_q.idx > norm) && !start && !sym_tick) |=>
            (st_q.idx == $past(st_q.idx)));
endmodule

// File: rtl/acq_cmd_sequencer.sv
module acq_cmd_sequencer
    import acq_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int STEP_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rx_mode,
    input  logic             sym_tick,
    input  logic [IDX_W-1:0] pll_norm,
    input  logic [IDX_W-1:0] lev_norm,
    output logic [IDX_W-1:0] pll_idx,
    output logic [IDX_W-1:0] lev_idx,
    output logic             pll_busy,
    output logic             lev_busy,
    output logic             crc_zero,
    output logic             tx_shape,
    output logic [2:0]       task_code
);
    localparam int N_RAMP = 2;

    cmd_fields_t      fields;
    logic             pll_start, lev_start;
    logic             start_v [N_RAMP];
    logic [IDX_W-1:0] norm_v  [N_RAMP];
    logic [IDX_W-1:0] idx_v   [N_RAMP];
    logic             busy_v  [N_RAMP];

    acq_cmd_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rx_mode   (rx_mode),
        .fields    (fields),
        .pll_start (pll_start),
        .lev_start (lev_start)
    );

    assign start_v[0] = pll_start;
    assign start_v[1] = lev_start;
    assign norm_v[0]  = pll_norm;
    assign norm_v[1]  = lev_norm;

    for (genvar g = 0; g < N_RAMP; g++) begin : g_ramp
        acq_ramp #(
            .IDX_W      (IDX_W),
            .STEP_TICKS (STEP_TICKS)
        ) u_ramp (
            .clk      (clk),
            .rst      (rst),
            .start    (start_v[g]),
            .sym_tick (sym_tick),
            .norm     (norm_v[g]),
            .idx      (idx_v[g]),
            .busy     (busy_v[g])
        );
    end

    assign pll_idx   = idx_v[0];
    assign lev_idx   = idx_v[1];
    assign pll_busy  = busy_v[0];
    assign lev_busy  = busy_v[1];
    assign crc_zero  = fields.crc_zero;
    assign tx_shape  = fields.tx_shape;
    assign task_code = fields.task_code;

    a_r5_tx_blocks_pll: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rx_mode && !pll_busy) |=> !pll_busy);

    a_r5_tx_blocks_lev: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rx_mode && !lev_busy) |=> !lev_busy);

    a_r2_crc_latch: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (crc_zero == $past(wr_data[5])));
endmodule

// File: tb/acq_cmd_sequencer_tb_top.sv
module acq_cmd_sequencer_tb_top;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             rx_mode = 1'b1;
    logic             sym_tick = 1'b0;
    logic [IDX_W-1:0] pll_norm = 3'd2;
    logic [IDX_W-1:0] lev_norm = 3'd1;
    logic [IDX_W-1:0] pll_idx, lev_idx;
    logic             pll_busy, lev_busy, crc_zero, tx_shape;
    logic [2:0]       task_code;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    acq_cmd_sequencer #(.IDX_W(IDX_W), .STEP_TICKS(4)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rx_mode(rx_mode), .sym_tick(sym_tick),
        .pll_norm(pll_norm), .lev_norm(lev_norm),
        .pll_idx(pll_idx), .lev_idx(lev_idx),
        .pll_busy(pll_busy), .lev_busy(lev_busy),
        .crc_zero(crc_zero), .tx_shape(tx_shape), .task_code(task_code)
    );

    typedef struct packed {
        logic [7:0] data;
        logic       rx;
        logic       pb;
        logic       lb;
        logic       crc;
        logic       shp;
        logic [2:0] tsk;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        '{8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        '{8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{8'hC7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7},
        '{8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        '{8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0},
        '{8'hF5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5},
        '{8'h0A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic write_cmd(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); sym_tick = 1'b1;
        repeat (n) @(negedge clk);
        sym_tick = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 reset state", {pll_busy, lev_busy, pll_idx, lev_idx, crc_zero, tx_shape, task_code},
            {1'b0, 1'b0, 3'd2, 3'd1, 1'b0, 1'b0, 3'd0});

        // R2/R3/R4/R5: table of command bytes
        for (int i = 0; i < NV; i++) begin
            do_reset();
            rx_mode = VECS[i].rx;
            write_cmd(VECS[i].data);
            chk($sformatf("R2/R3/R4/R5 vector %0d", i),
                {pll_busy, lev_busy, pll_idx, lev_idx, crc_zero, tx_shape, task_code},
                {VECS[i].pb, VECS[i].lb, (VECS[i].pb ? 3'd7 : 3'd2), (VECS[i].lb ? 3'd7 : 3'd1),
                 VECS[i].crc, VECS[i].shp, VECS[i].tsk});
            rx_mode = 1'b1;
        end

        // R6: full descent of the timing-loop ramp
        do_reset();
        write_cmd(8'h80);
        for (int s = 6; s >= 2; s--) begin
            ticks(3);
            chk("R6 no step before 4 ticks", {29'd0, pll_idx}, s + 1);
            ticks(1);
            chk("R6 step index", {29'd0, pll_idx}, s);
            chk("R6 busy", {31'd0, pll_busy}, (s > 2) ? 1 : 0);
        end
        repeat (5) @(negedge clk);
        chk("R6 hold without ticks", {28'd0, pll_busy, pll_idx}, {28'd0, 1'b0, 3'd2});

        // R7/R8: restart and zero-bit write
        do_reset();
        write_cmd(8'h40);
        ticks(8);
        chk("R6 level index after 8 ticks", {29'd0, lev_idx}, 5);
        ticks(2);
        write_cmd(8'h40);
        chk("R7 restart at max", {28'd0, lev_busy, lev_idx}, {28'd0, 1'b1, 3'd7});
        ticks(3);
        chk("R7 tick count cleared", {29'd0, lev_idx}, 7);
        write_cmd(8'h00);
        chk("R8 zero bit keeps ramp", {28'd0, lev_busy, lev_idx}, {28'd0, 1'b1, 3'd7});
        ticks(1);
        chk("R8 ramp continues", {29'd0, lev_idx}, 6);

        // R9: normal value raised during ramp
        @(negedge clk); lev_norm = 3'd6;
        @(negedge clk);
        chk("R9 ramp ends at new normal", {28'd0, lev_busy, lev_idx}, {28'd0, 1'b0, 3'd6});
        @(negedge clk); lev_norm = 3'd3;
        @(negedge clk);
        chk("R9 idle follows normal", {28'd0, lev_busy, lev_idx}, {28'd0, 1'b0, 3'd3});

        // R10: normal already at maximum
        @(negedge clk); pll_norm = 3'd7;
        write_cmd(8'h80);
        chk("R10 launch at max normal", {28'd0, pll_busy, pll_idx}, {28'd0, 1'b0, 3'd7});

        // R1: reset during a running ramp
        pll_norm = 3'd2;
        write_cmd(8'hC0);
        do_reset();
        chk("R1 reset aborts ramps", {pll_busy, lev_busy, pll_idx, lev_idx},
            {1'b0, 1'b0, 3'd2, 3'd3});

        finish_run();
    end
endmodule